// File: doc/BRIEF.md
# Reset and Power-Mode Sequencer

This block gathers every reset source of a small microcontroller core and turns them into one registered core-reset output, a watchdog-driven pin pull-down, a three-level power state and a set of sticky reset-cause flags. The sources are power-on (asynchronous `por_n`), supply brownout, a watchdog timeout strobe, the external active-low reset pin, a software reset made by writing a magic byte to a special I2C address, and a programming-complete strobe gated by a reset-enable level. The watchdog counter, the I2C decoder, the voltage comparators and the oscillator live elsewhere and reach this block only as strobes and levels.

The controller is one state machine with nine states. ST_STARTUP counts the clock-startup delay after power-on or brownout recovery and then goes to ST_RUN. From ST_RUN, in priority order, a watchdog strobe goes to ST_WDT_HOLD, an internal request goes to ST_INT_HOLD, a qualified pin low goes to ST_EXT_HOLD, and a stop request goes to ST_STOP. ST_STOP goes back to ST_RUN on a port, I2C-start or supply-monitor wake event. In ST_STOP, a synchronized pin low goes instead to the short reset ST_WAKE. ST_EXT_HOLD waits for the pin to return high and then counts out ST_EXT_REL. ST_WDT_HOLD, ST_INT_HOLD, ST_EXT_REL and ST_WAKE each return to ST_RUN when their counter runs out. A high brownout input sends any state to ST_BROWNOUT, which goes to ST_STARTUP when the supply recovers.

Top module: `rstpm_ctrl`

## Requirements
- R1: A `wdt_timeout` strobe sampled in ST_RUN asserts `core_rst` and `pin_drv_low` from the next clock edge, and both stay high for exactly 12 cycles.
- R2: A watchdog reset sets cause flag bit 1. The flag stays set until it is cleared.
- R3: `ext_rst_n` passes through a two-flop synchronizer. In ST_RUN, a pin low held across 4 consecutive sampling edges asserts `core_rst` at the 6th edge after the first low sample and sets cause bit 2. A pin low held across only 3 edges has no effect.
- R4: Once external reset is entered, `core_rst` stays high for as long as the pin stays low. `core_rst` is released at the 11th edge after the pin returns high, which is within 12 cycles.
- R5: A write strobe with address 0x34 and data 0xBB, or `isp_done` with `isp_rst_en` high, holds `core_rst` for 12 cycles and sets cause bit 3, with `pin_drv_low` staying low. A write with any other address or data has no effect, and neither does `isp_done` while `isp_rst_en` is low.
- R6: `stop_set` in ST_RUN moves `pwr_state` to 2 (stop) at the next edge with `core_rst` low. A `wake_port`, `wake_i2c_start` or `wake_svm` pulse in stop returns `pwr_state` to 1 (run) at the next edge, and `core_rst` stays low.
- R7: A pin low in stop asserts `core_rst` at the 3rd edge and releases it into run at the 9th edge (within 10), setting cause bit 2.
- R8: While `brownout` is high, in any state, `core_rst` is high and `pwr_state` is 0 from the next edge. After recovery the core runs again STARTUP_CYC + 1 edges after the first low sample.
- R9: Power-on reset gives `core_rst` = 1, `pwr_state` = 1 and cause flags = 0001 (bit 0 only). After `por_n` rises, `core_rst` falls at the 16th edge (STARTUP_CYC = 16).
- R10: A one bit in `cause_clr` clears that cause flag at the next edge. A set in the same cycle wins over the clear.
- R11: When sources coincide in ST_RUN, brownout wins over watchdog, watchdog over internal, and internal over external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| brownout | input | 1 | Supply below brownout threshold (level) |
| wdt_timeout | input | 1 | Watchdog elapsed strobe |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| i2c_wr_stb | input | 1 | One-cycle I2C data write strobe |
| i2c_addr | input | 7 | Slave address of the write |
| i2c_data | input | 8 | Data byte of the write |
| isp_done | input | 1 | In-system programming complete strobe |
| isp_rst_en | input | 1 | Reset-on-programming-done enable level |
| stop_set | input | 1 | Stop request strobe |
| wake_port | input | 1 | Port interrupt wake event |
| wake_i2c_start | input | 1 | I2C start interrupt wake event |
| wake_svm | input | 1 | Supply-monitor interrupt wake event |
| cause_clr | input | 4 | Write-one-to-clear strobe for the cause flags |
| core_rst | output | 1 | Registered core reset, active high |
| pin_drv_low | output | 1 | Pull reset pin low during a watchdog reset |
| pwr_state | output | 2 | 0 brownout, 1 run, 2 stop |
| cause_flags | output | 4 | Sticky causes: 0 power-on, 1 watchdog, 2 external, 3 internal |

## Verification
A wrong state register shows up on `core_rst` and `pwr_state` at the edge after the faulty transition, because both are registered from the next-state decode. A wrong hold counter shows up as a reset pulse that is one or more cycles too long or too short at its falling edge, up to 16 cycles after entry. Faults in the qualification counter or the synchronizer show up as a 3-cycle pin pulse causing a reset, or as entry that comes one edge early or late. A wrong priority or a wrong cause encoding shows up in `cause_flags` at the first edge after the coinciding stimulus.

// File: rtl/rstpm_pkg.sv
package rstpm_pkg;

    typedef enum logic [3:0] {
        ST_STARTUP  = 4'd0,
        ST_RUN      = 4'd1,
        ST_STOP     = 4'd2,
        ST_BROWNOUT = 4'd3,
        ST_WDT_HOLD = 4'd4,
        ST_INT_HOLD = 4'd5,
        ST_EXT_HOLD = 4'd6,
        ST_EXT_REL  = 4'd7,
        ST_WAKE     = 4'd8
    } seq_state_e;

    typedef enum logic [1:0] {
        PWR_BROWNOUT = 2'd0,
        PWR_RUN      = 2'd1,
        PWR_STOP     = 2'd2
    } pwr_state_e;

    localparam int CAUSE_POR = 0;
    localparam int CAUSE_WDT = 1;
    localparam int CAUSE_EXT = 2;
    localparam int CAUSE_INT = 3;
    localparam int N_CAUSE   = 4;

endpackage

// File: rtl/rstpm_pin_qual.sv
module rstpm_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low_sync,
    output logic qual_low
);
    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [QW-1:0]          low_cnt;

    // synchronizer chain, idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign pin_low_sync = !sync_q[SYNC_STAGES-1];

    // consecutive-low counter, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_cnt <= '0;
        else if (!pin_low_sync)   low_cnt <= '0;
        else if (low_cnt != QMAX) low_cnt <= low_cnt + QW'(1);
    end

    assign qual_low = pin_low_sync && (low_cnt == QMAX);

endmodule

// File: rtl/rstpm_cause.sv
module rstpm_cause #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= RST_VAL[i];
            else if (set_i[i]) flag_q <= 1'b1;
            else if (clr_i[i]) flag_q <= 1'b0;
        end
        assign flags_o[i] = flag_q;
    end

endmodule

// File: rtl/rstpm_ctrl.sv
module rstpm_ctrl
    import rstpm_pkg::*;
#(
    parameter int         STARTUP_CYC = 16,
    parameter int         HOLD_CYC    = 12,
    parameter int         EXT_REL_CYC = 8,
    parameter int         WAKE_CYC    = 6,
    parameter int         QUAL_CYC    = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SW_RST_ADDR = 7'h34,
    parameter logic [7:0] SW_RST_DATA = 8'hBB
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       brownout,
    input  logic       wdt_timeout,
    input  logic       ext_rst_n,
    input  logic       i2c_wr_stb,
    input  logic [6:0] i2c_addr,
    input  logic [7:0] i2c_data,
    input  logic       isp_done,
    input  logic       isp_rst_en,
    input  logic       stop_set,
    input  logic       wake_port,
    input  logic       wake_i2c_start,
    input  logic       wake_svm,
    input  logic [3:0] cause_clr,
    output logic       core_rst,
    output logic       pin_drv_low,
    output logic [1:0] pwr_state,
    output logic [3:0] cause_flags
);
    localparam int M1      = (STARTUP_CYC > HOLD_CYC) ? STARTUP_CYC : HOLD_CYC;
    localparam int M2      = (EXT_REL_CYC > WAKE_CYC) ? EXT_REL_CYC : WAKE_CYC;
    localparam int MAX_CYC = (M1 > M2) ? M1 : M2;
    localparam int CW      = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] LD_STARTUP = CW'(STARTUP_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD    = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_EXT_REL = CW'(EXT_REL_CYC - 1);
    localparam logic [CW-1:0] LD_WAKE    = CW'(WAKE_CYC - 1);

    seq_state_e         st_q, st_d;
    logic [CW-1:0]      cnt_q, cnt_d;
    logic [N_CAUSE-1:0] cause_set;
    logic               pin_low_sync, pin_qual;
    logic               int_req, wake_evt;

    rstpm_pin_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_CYC    (QUAL_CYC)
    ) u_pin (
        .clk          (clk),
        .rst_n        (por_n),
        .pin_n        (ext_rst_n),
        .pin_low_sync (pin_low_sync),
        .qual_low     (pin_qual)
    );

    rstpm_cause #(
        .N       (N_CAUSE),
        .RST_VAL (N_CAUSE'(1) << CAUSE_POR)
    ) u_cause (
        .clk     (clk),
        .rst_n   (por_n),
        .set_i   (cause_set),
        .clr_i   (cause_clr),
        .flags_o (cause_flags)
    );

    assign int_req  = (i2c_wr_stb && (i2c_addr == SW_RST_ADDR) && (i2c_data == SW_RST_DATA))
                    || (isp_done && isp_rst_en);
    assign wake_evt = wake_port || wake_i2c_start || wake_svm;

    // next-state logic
    always_comb begin
        st_d      = st_q;
        cnt_d     = (cnt_q != '0) ? cnt_q - CW'(1) : cnt_q;
        cause_set = '0;
        if (brownout) begin
            st_d = ST_BROWNOUT;
        end else begin
            unique case (st_q)
                ST_STARTUP, ST_WDT_HOLD, ST_INT_HOLD, ST_EXT_REL, ST_WAKE: begin
                    if (cnt_q == '0) st_d = ST_RUN;
                end
                ST_BROWNOUT: begin
                    st_d  = ST_STARTUP;
                    cnt_d = LD_STARTUP;
                end
                ST_RUN: begin
                    if (wdt_timeout) begin
                        st_d                 = ST_WDT_HOLD;
                        cnt_d                = LD_HOLD;
                        cause_set[CAUSE_WDT] = 1'b1;
                    end else if (int_req) begin
                        st_d                 = ST_INT_HOLD;
                        cnt_d                = LD_HOLD;
                        cause_set[CAUSE_INT] = 1'b1;
                    end else if (pin_qual) begin
                        st_d                 = ST_EXT_HOLD;
                        cause_set[CAUSE_EXT] = 1'b1;
                    end else if (stop_set) begin
                        st_d = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (pin_low_sync) begin
                        st_d                 = ST_WAKE;
                        cnt_d                = LD_WAKE;
                        cause_set[CAUSE_EXT] = 1'b1;
                    end else if (wake_evt) begin
                        st_d = ST_RUN;
                    end
                end
                ST_EXT_HOLD: begin
                    if (!pin_low_sync) begin
                        st_d  = ST_EXT_REL;
                        cnt_d = LD_EXT_REL;
                    end
                end
                default: begin
                    st_d  = ST_STARTUP;
                    cnt_d = LD_STARTUP;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= ST_STARTUP;
            cnt_q <= LD_STARTUP;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // registered outputs from the next state
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            core_rst    <= 1'b1;
            pin_drv_low <= 1'b0;
            pwr_state   <= PWR_RUN;
        end else begin
            core_rst    <= !((st_d == ST_RUN) || (st_d == ST_STOP));
            pin_drv_low <= (st_d == ST_WDT_HOLD);
            unique case (st_d)
                ST_BROWNOUT: pwr_state <= PWR_BROWNOUT;
                ST_STOP:     pwr_state <= PWR_STOP;
                default:     pwr_state <= PWR_RUN;
            endcase
        end
    end

endmodule

// File: rtl/rstpm_ctrl_chk.sv
module rstpm_ctrl_chk
    import rstpm_pkg::*;
#(
    parameter int HOLD_CYC = 12
) (
    input logic       clk,
    input logic       por_n,
    input logic       brownout,
    input logic       core_rst,
    input logic       pin_drv_low,
    input logic [1:0] pwr_state,
    input logic [3:0] cause_flags
);
    localparam int RW = $clog2(HOLD_CYC + 2);
    logic [RW-1:0] drv_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)           drv_run <= '0;
        else if (pin_drv_low) drv_run <= drv_run + RW'(1);
        else                  drv_run <= '0;
    end

    AST_PIN_IMPLIES_RST: assert property (@(posedge clk) disable iff (!por_n)
        pin_drv_low |-> core_rst); // R1

    AST_PIN_NO_OVERRUN: assert property (@(posedge clk) disable iff (!por_n)
        drv_run <= RW'(HOLD_CYC)); // R1

    AST_PIN_FULL_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(pin_drv_low) && pwr_state != PWR_BROWNOUT) |-> drv_run == RW'(HOLD_CYC)); // R1

    AST_WDT_FLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pin_drv_low) |-> cause_flags[CAUSE_WDT]); // R2

    AST_STOP_NOT_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (pwr_state == PWR_STOP) |-> !core_rst); // R6

    AST_BROWNOUT_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        brownout |=> (core_rst && pwr_state == PWR_BROWNOUT)); // R8

endmodule

bind rstpm_ctrl rstpm_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (.*);

// File: tb/rstpm_ctrl_test.sv
`timescale 1ns/1ps
module rstpm_ctrl_test;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       brownout = 1'b0, wdt_timeout = 1'b0, ext_rst_n = 1'b1;
    logic       i2c_wr_stb = 1'b0;
    logic [6:0] i2c_addr = '0;
    logic [7:0] i2c_data = '0;
    logic       isp_done = 1'b0, isp_rst_en = 1'b0, stop_set = 1'b0;
    logic       wake_port = 1'b0, wake_i2c_start = 1'b0, wake_svm = 1'b0;
    logic [3:0] cause_clr = '0;
    logic       core_rst, pin_drv_low;
    logic [1:0] pwr_state;
    logic [3:0] cause_flags;

    rstpm_ctrl uut (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    localparam int F_RST = 0, F_PIN = 1, F_PWR = 2, F_FLG = 3;

    typedef struct {
        int    at;
        string req;
        int    fld;
        int    val;
    } exp_t;

    exp_t sb[$];

    function automatic int actual(int f);
        case (f)
            F_RST:   return int'(core_rst);
            F_PIN:   return int'(pin_drv_low);
            F_PWR:   return int'(pwr_state);
            default: return int'(cause_flags);
        endcase
    endfunction

    function automatic string fname(int f);
        case (f)
            F_RST:   return "core_rst";
            F_PIN:   return "pin_drv_low";
            F_PWR:   return "pwr_state";
            default: return "cause_flags";
        endcase
    endfunction

    // driver side: expected value d edges from now
    task automatic expect_at(int d, string r, int f, int v);
        exp_t e;
        e.at = cyc + d; e.req = r; e.fld = f; e.val = v;
        sb.push_back(e);
    endtask

    task automatic check_now(string r, int f, int v);
        total++;
        if (actual(f) != v) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, fname(f), actual(f), v);
        end
    endtask

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            total++;
            if (e.at < cyc) begin
                bad++;
                $display("FAIL %s %s missed at=%0d actual=%0d expected=%0d",
                         e.req, fname(e.fld), e.at, actual(e.fld), e.val);
            end else if (actual(e.fld) != e.val) begin
                bad++;
                $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d",
                         e.req, fname(e.fld), cyc, actual(e.fld), e.val);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags(logic [3:0] m, int expv);
        cause_clr = m;
        expect_at(1, "R10", F_FLG, expv);
        step(1);
        cause_clr = '0;
        step(1);
    endtask

    task automatic pin_low(int n);
        ext_rst_n = 1'b0;
        step(n);
        ext_rst_n = 1'b1;
    endtask

    task automatic i2c_write(logic [6:0] a, logic [7:0] d);
        i2c_wr_stb = 1'b1; i2c_addr = a; i2c_data = d;
        step(1);
        i2c_wr_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog run did not finish");
            done = 1;
            finish_run();
        end
    end

    initial begin
        // R9 power-on state
        step(3);
        check_now("R9", F_RST, 1);
        check_now("R9", F_PWR, 1);
        check_now("R9", F_FLG, 4'b0001);
        por_n = 1'b1;
        expect_at(15, "R9", F_RST, 1);
        expect_at(16, "R9", F_RST, 0);
        expect_at(16, "R9", F_FLG, 4'b0001);
        step(20);
        clear_flags(4'b0001, 0);

        // R1 R2 watchdog
        wdt_timeout = 1'b1;
        expect_at(1,  "R1", F_RST, 1);
        expect_at(1,  "R1", F_PIN, 1);
        expect_at(1,  "R2", F_FLG, 4'b0010);
        expect_at(12, "R1", F_RST, 1);
        expect_at(12, "R1", F_PIN, 1);
        expect_at(13, "R1", F_RST, 0);
        expect_at(13, "R1", F_PIN, 0);
        expect_at(25, "R2", F_FLG, 4'b0010);
        step(1); wdt_timeout = 1'b0;
        step(28);
        clear_flags(4'b0010, 0);

        // R3 three-cycle pulse ignored
        expect_at(5,  "R3", F_RST, 0);
        expect_at(8,  "R3", F_RST, 0);
        expect_at(10, "R3", F_FLG, 0);
        pin_low(3);
        step(12);

        // R3 R4 four-cycle pulse
        expect_at(5,  "R3", F_RST, 0);
        expect_at(6,  "R3", F_RST, 1);
        expect_at(6,  "R3", F_FLG, 4'b0100);
        expect_at(14, "R4", F_RST, 1);
        expect_at(15, "R4", F_RST, 0);
        pin_low(4);
        step(16);
        clear_flags(4'b0100, 0);

        // R4 long low held
        expect_at(6,  "R4", F_RST, 1);
        expect_at(12, "R4", F_RST, 1);
        expect_at(18, "R4", F_RST, 1);
        expect_at(19, "R4", F_RST, 0);
        pin_low(8);
        step(16);
        clear_flags(4'b0100, 0);

        // R5 wrong data and wrong address ignored
        expect_at(1, "R5", F_RST, 0);
        expect_at(2, "R5", F_RST, 0);
        expect_at(3, "R5", F_FLG, 0);
        i2c_write(7'h34, 8'hBA);
        i2c_write(7'h35, 8'hBB);
        step(2);
        // R5 software reset
        expect_at(1,  "R5", F_RST, 1);
        expect_at(1,  "R5", F_PIN, 0);
        expect_at(1,  "R5", F_FLG, 4'b1000);
        expect_at(12, "R5", F_RST, 1);
        expect_at(13, "R5", F_RST, 0);
        i2c_write(7'h34, 8'hBB);
        step(14);
        clear_flags(4'b1000, 0);
        // R5 programming done without and with enable
        isp_done = 1'b1; isp_rst_en = 1'b0;
        expect_at(1, "R5", F_RST, 0);
        step(1); isp_done = 1'b0;
        step(2);
        isp_done = 1'b1; isp_rst_en = 1'b1;
        expect_at(1,  "R5", F_RST, 1);
        expect_at(12, "R5", F_RST, 1);
        expect_at(13, "R5", F_RST, 0);
        step(1); isp_done = 1'b0; isp_rst_en = 1'b0;
        step(14);
        clear_flags(4'b1000, 0);

        // R6 stop and wake by port
        stop_set = 1'b1;
        expect_at(1, "R6", F_PWR, 2);
        expect_at(1, "R6", F_RST, 0);
        step(1); stop_set = 1'b0;
        step(3);
        wake_port = 1'b1;
        expect_at(1, "R6", F_PWR, 1);
        expect_at(1, "R6", F_RST, 0);
        step(1); wake_port = 1'b0;
        step(2);
        // R6 wake by supply monitor
        stop_set = 1'b1;
        step(1); stop_set = 1'b0;
        step(2);
        wake_svm = 1'b1;
        expect_at(1, "R6", F_PWR, 1);
        step(1); wake_svm = 1'b0;
        step(2);

        // R7 pin pulse in stop
        stop_set = 1'b1;
        step(1); stop_set = 1'b0;
        step(2);
        expect_at(2, "R7", F_RST, 0);
        expect_at(3, "R7", F_RST, 1);
        expect_at(3, "R7", F_FLG, 4'b0100);
        expect_at(8, "R7", F_RST, 1);
        expect_at(9, "R7", F_RST, 0);
        expect_at(9, "R7", F_PWR, 1);
        pin_low(2);
        step(12);
        clear_flags(4'b0100, 0);

        // R8 brownout from run
        brownout = 1'b1;
        expect_at(1,  "R8", F_PWR, 0);
        expect_at(1,  "R8", F_RST, 1);
        expect_at(21, "R8", F_RST, 1);
        expect_at(22, "R8", F_RST, 0);
        expect_at(22, "R8", F_FLG, 0);
        step(5); brownout = 1'b0;
        step(20);
        // R8 brownout from stop
        stop_set = 1'b1;
        step(1); stop_set = 1'b0;
        step(2);
        brownout = 1'b1;
        expect_at(1,  "R8", F_PWR, 0);
        expect_at(19, "R8", F_RST, 0);
        expect_at(19, "R8", F_PWR, 1);
        step(2); brownout = 1'b0;
        step(20);

        // R11 watchdog beats internal
        wdt_timeout = 1'b1; i2c_wr_stb = 1'b1; i2c_addr = 7'h34; i2c_data = 8'hBB;
        expect_at(1, "R11", F_FLG, 4'b0010);
        expect_at(1, "R11", F_PIN, 1);
        step(1);
        wdt_timeout = 1'b0; i2c_wr_stb = 1'b0;
        step(14);
        clear_flags(4'b0010, 0);
        // R11 brownout beats watchdog
        brownout = 1'b1; wdt_timeout = 1'b1;
        expect_at(1, "R11", F_PWR, 0);
        expect_at(1, "R11", F_FLG, 0);
        expect_at(1, "R11", F_PIN, 0);
        step(1);
        brownout = 1'b0; wdt_timeout = 1'b0;
        step(20);

        // R10 set wins over clear in the same cycle
        wdt_timeout = 1'b1; cause_clr = 4'b0010;
        expect_at(1, "R10", F_FLG, 4'b0010);
        step(1);
        wdt_timeout = 1'b0; cause_clr = '0;
        step(16);
        clear_flags(4'b0010, 0);

        step(4);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard %0d items left actual=%0d expected=0", sb.size(), sb.size());
        end
        done = 1;
        finish_run();
    end

endmodule